// File: doc/BRIEF.md
# Tagged stack register file

This block is a file of eight 80-bit registers that can be reached in two ways. In stack mode, every access names an entry relative to a rotating top-of-stack pointer. The commands are push, pop, read of the i-th stack entry and write of the i-th stack entry. In flat mode, 64-bit packed-integer accesses name the same storage by absolute register number and ignore the pointer.

Every register carries a 2-bit class tag. The tag is computed from the exponent and mantissa of each value written through the stack port. The overflow and underflow checks use the tags, and one command marks every entry empty at once.

One command is accepted per cycle on a single opcode port. Read results, the current pointer and two sticky error flags are driven from registers.

Top module: `tagged_stack_rf`

## Requirements
- R1: After synchronous reset, `tos` is 0, both error flags are 0, `rd_valid` is 0 and every tag is empty.
- R2: Tags encode 00 = valid, 01 = zero, 10 = special, 11 = empty. A stack-port write is classed zero when exponent bits 78:64 and mantissa bits 63:0 are all zero. It is classed special when the exponent is all ones, or when the exponent is zero and the mantissa is nonzero. Every other value is classed valid.
- R3: Push (opcode 1) first moves `tos` down by one modulo 8, then stores the data and its class in the new top entry. If that target entry is not empty, the push sets the sticky `ovf_flag`, writes nothing and leaves `tos` unchanged.
- R4: Pop (opcode 2) returns the top entry's data and tag on the read port, marks that entry empty and moves `tos` up by one modulo 8. A pop of an empty top entry sets the sticky `unf_flag` and changes no state.
- R5: Read stack entry (opcode 3) returns the data and tag of physical register (`tos` + `op_idx`) mod 8. If that entry is empty, the read sets `unf_flag`.
- R6: Write stack entry (opcode 4) stores the data in physical register (`tos` + `op_idx`) mod 8 with its computed class. `tos` does not change.
- R7: Flat write (opcode 6) stores `op_wdata[63:0]` in bits 63:0 of register `op_idx` and sets bits 79:64 to all ones. It also clears `tos` to 0 and marks all eight tags valid.
- R8: Flat read (opcode 5) returns zeros in bits 79:64 and bits 63:0 of register `op_idx` with no pointer offset, together with that entry's tag. It never sets `unf_flag`.
- R9: Empty-all (opcode 7) marks all eight tags empty and leaves the register data and `tos` unchanged.
- R10: A read, pop or flat read accepted on one clock edge raises `rd_valid` for exactly the following cycle, with `rd_data` and `rd_tag` valid in that cycle. Opcode 0, and any cycle with `op_valid` low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 3 | Command code (0 none, 1 push, 2 pop, 3 read stack, 4 write stack, 5 flat read, 6 flat write, 7 empty-all) |
| op_idx | input | 3 | Stack offset or absolute register number |
| op_wdata | input | 80 | Write data (flat write uses bits 63:0) |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 80 | Read result data |
| rd_tag | output | 2 | Class tag of the entry read |
| tos | output | 3 | Current top-of-stack index |
| ovf_flag | output | 1 | Sticky stack overflow |
| unf_flag | output | 1 | Sticky stack underflow |

## Verification
The bench drives the pointer across its wrap in both directions: a push from index 0 must land in entry 7, and pops must climb back to 0. A design with a wrong modulo or a wrong sign would read back the wrong register. The ninth push on a full file must leave both the pointer and the data untouched; a design that wrote anyway would corrupt the top value. A flat read taken after the pointer has moved must ignore the offset, and a design that added it would return a neighbouring register. After empty-all, the data must survive while every tag reads empty; a design that cleared the storage, or missed a tag, would fail the later flat read or the underflow check.

// File: rtl/tsrf_pkg.sv
package tsrf_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_RD_ST   = 3'd3,
    OP_WR_ST   = 3'd4,
    OP_FLAT_RD = 3'd5,
    OP_FLAT_WR = 3'd6,
    OP_EMPTY   = 3'd7
  } op_e;
endpackage

// File: rtl/tsrf_classify.sv
module tsrf_classify #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] value,
  output logic [1:0]           cls
);
  import tsrf_pkg::*;
  localparam int WIDTH = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic exp_zero, exp_ones, man_zero;

  assign exp_f    = value[WIDTH-2 -: EXP_W];
  assign man_f    = value[MAN_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_ones = (&exp_f);
  assign man_zero = (man_f == '0);

  always_comb begin
    if (exp_zero && man_zero)        cls = TAG_ZERO;
    else if (exp_ones || exp_zero)   cls = TAG_SPECIAL;
    else                             cls = TAG_VALID;
  end
endmodule

// File: rtl/tsrf_data_ram.sv
module tsrf_data_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsrf_tag_file.sv
module tsrf_tag_file #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     set_en,
  input  logic [$clog2(DEPTH)-1:0] set_idx,
  input  logic [1:0]               set_val,
  input  logic                     all_empty,
  input  logic                     all_valid,
  output logic [DEPTH-1:0][1:0]    tags_q
);
  import tsrf_pkg::*;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst || all_empty)                 tags_q[g] <= TAG_EMPTY;
      else if (all_valid)                   tags_q[g] <= TAG_VALID;
      else if (set_en && set_idx == g)      tags_q[g] <= set_val;
    end
  end

  // R9: an empty-all command leaves every entry tagged empty
  p_all_empty_r9: assert property (@(posedge clk) disable iff (rst)
    all_empty |=> (&tags_q));
  // R7: a flat write leaves every entry tagged valid
  p_all_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (all_valid && !all_empty) |=> (tags_q == '0));
endmodule

// File: rtl/tagged_stack_rf.sv
module tagged_stack_rf #(
  parameter int DEPTH = 8,
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       op_valid,
  input  logic [2:0]                 op_code,
  input  logic [$clog2(DEPTH)-1:0]   op_idx,
  input  logic [EXP_W+MAN_W:0]       op_wdata,
  output logic                       rd_valid,
  output logic [EXP_W+MAN_W:0]       rd_data,
  output logic [1:0]                 rd_tag,
  output logic [$clog2(DEPTH)-1:0]   tos,
  output logic                       ovf_flag,
  output logic                       unf_flag
);
  import tsrf_pkg::*;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int WIDTH = EXP_W + MAN_W + 1;
  localparam int HIGHW = WIDTH - MAN_W;

  logic [IDXW-1:0]         tos_q, st_addr, push_addr, rd_addr, wr_addr;
  logic [DEPTH-1:0][1:0]   tags_q;
  logic [1:0]              new_cls, set_val;
  logic [WIDTH-1:0]        wr_data, ram_q;
  logic is_push, is_pop, is_rd_st, is_wr_st, is_flat_rd, is_flat_wr, is_empty;
  logic push_ok, pop_ok, is_read, wr_en, set_en, rd_empty, flat_q;

  assign is_push    = op_valid && op_code == OP_PUSH;
  assign is_pop     = op_valid && op_code == OP_POP;
  assign is_rd_st   = op_valid && op_code == OP_RD_ST;
  assign is_wr_st   = op_valid && op_code == OP_WR_ST;
  assign is_flat_rd = op_valid && op_code == OP_FLAT_RD;
  assign is_flat_wr = op_valid && op_code == OP_FLAT_WR;
  assign is_empty   = op_valid && op_code == OP_EMPTY;
  assign is_read    = is_pop || is_rd_st || is_flat_rd;

  assign st_addr   = tos_q + op_idx;
  assign push_addr = tos_q - IDXW'(1);
  assign push_ok   = is_push && tags_q[push_addr] == TAG_EMPTY;
  assign pop_ok    = is_pop && tags_q[tos_q] != TAG_EMPTY;

  always_comb begin
    if (is_pop)        rd_addr = tos_q;
    else if (is_rd_st) rd_addr = st_addr;
    else               rd_addr = op_idx;
  end
  assign rd_empty = tags_q[rd_addr] == TAG_EMPTY;

  always_comb begin
    if (push_ok)       wr_addr = push_addr;
    else if (is_wr_st) wr_addr = st_addr;
    else               wr_addr = op_idx;
  end
  assign wr_en   = push_ok || is_wr_st || is_flat_wr;
  assign wr_data = is_flat_wr ? {{HIGHW{1'b1}}, op_wdata[MAN_W-1:0]} : op_wdata;

  assign set_en  = push_ok || is_wr_st || pop_ok;
  assign set_val = pop_ok ? TAG_EMPTY : new_cls;

  tsrf_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .value(op_wdata), .cls(new_cls));

  tsrf_data_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(ram_q));

  tsrf_tag_file #(.DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst(rst), .set_en(set_en),
    .set_idx(pop_ok ? tos_q : wr_addr), .set_val(set_val),
    .all_empty(is_empty), .all_valid(is_flat_wr), .tags_q(tags_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q    <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      rd_valid <= 1'b0;
      rd_tag   <= TAG_EMPTY;
      flat_q   <= 1'b0;
    end else begin
      if (push_ok)         tos_q <= push_addr;
      else if (pop_ok)     tos_q <= tos_q + IDXW'(1);
      else if (is_flat_wr) tos_q <= '0;
      if (is_push && !push_ok)                ovf_flag <= 1'b1;
      if ((is_pop || is_rd_st) && rd_empty)   unf_flag <= 1'b1;
      rd_valid <= is_read;
      if (is_read) begin
        rd_tag <= tags_q[rd_addr];
        flat_q <= is_flat_rd;
      end
    end
  end

  assign tos     = tos_q;
  assign rd_data = flat_q ? {{HIGHW{1'b0}}, ram_q[MAN_W-1:0]} : ram_q;

  // R3: overflow is sticky
  p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);
  // R3: a push onto an occupied entry leaves the pointer in place
  p_push_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (is_push && tags_q[push_addr] != TAG_EMPTY) |=> tos_q == $past(tos_q));
  // R4: underflow is sticky
  p_unf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    unf_flag |=> unf_flag);
  // R4: a successful pop leaves the old top entry empty
  p_pop_empties_r4: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> tags_q[$past(tos_q)] == TAG_EMPTY);
  // R7: a flat write returns the pointer to zero
  p_flat_tos_r7: assert property (@(posedge clk) disable iff (rst)
    is_flat_wr |=> tos_q == '0);
  // R10: read result valid exactly one cycle after a read command
  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    is_read |=> rd_valid);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !is_read |=> !rd_valid);
endmodule

// File: tb/test_tagged_stack_rf.sv
module test_tagged_stack_rf;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [2:0]  op_idx;
  logic [79:0] op_wdata;
  logic        rd_valid;
  logic [79:0] rd_data;
  logic [1:0]  rd_tag;
  logic [2:0]  tos;
  logic        ovf_flag, unf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [79:0] V_NORM = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] V_ZERO = 80'h0;
  localparam logic [79:0] V_INF  = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] V_DEN  = 80'h0000_0000_0000_0000_0001;
  localparam logic [79:0] V_NEG  = 80'hC001_C000_0000_0000_1234;

  always #5 clk = ~clk;

  tagged_stack_rf i_tagged_stack_rf (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_idx(op_idx), .op_wdata(op_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_tag(rd_tag), .tos(tos),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one command on a falling edge; outputs are sampled at the next falling edge
  task automatic do_op(input logic [2:0] code, input logic [2:0] idx, input logic [79:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_idx = idx; op_wdata = d;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; op_code = 3'd0; op_idx = 3'd0; op_wdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 tos", 80'(tos), 80'd0);
    check("R1 ovf", 80'(ovf_flag), 80'd0);
    check("R1 unf", 80'(unf_flag), 80'd0);
    check("R1 rd_valid", 80'(rd_valid), 80'd0);
    do_op(3'd5, 3'd4, '0);
    check("R1 tag empty", 80'(rd_tag), 80'd3);
  endtask

  task automatic t_push_classes();
    do_reset();
    do_op(3'd1, 3'd0, V_NORM);
    check("R3 wrap tos", 80'(tos), 80'd7);
    check("R10 no rd after push", 80'(rd_valid), 80'd0);
    do_op(3'd3, 3'd0, '0);
    check("R10 rd_valid", 80'(rd_valid), 80'd1);
    check("R5 data", rd_data, V_NORM);
    check("R2 valid tag", 80'(rd_tag), 80'd0);
    do_op(3'd1, 3'd0, V_ZERO);
    do_op(3'd1, 3'd0, V_INF);
    do_op(3'd1, 3'd0, V_DEN);
    check("R3 tos after 4", 80'(tos), 80'd4);
    do_op(3'd3, 3'd2, '0);
    check("R2 zero tag", 80'(rd_tag), 80'd1);
    do_op(3'd3, 3'd1, '0);
    check("R2 inf special", 80'(rd_tag), 80'd2);
    check("R5 inf data", rd_data, V_INF);
    do_op(3'd3, 3'd0, '0);
    check("R2 denormal special", 80'(rd_tag), 80'd2);
    do_op(3'd3, 3'd3, '0);
    check("R5 offset 3", rd_data, V_NORM);
    do_op(3'd4, 3'd2, V_NEG);
    check("R6 tos kept", 80'(tos), 80'd4);
    do_op(3'd3, 3'd2, '0);
    check("R6 data", rd_data, V_NEG);
    check("R6 tag", 80'(rd_tag), 80'd0);
    check("R5 no unf", 80'(unf_flag), 80'd0);
  endtask

  task automatic t_pop_underflow();
    do_op(3'd2, 3'd0, '0);
    check("R4 pop data", rd_data, V_DEN);
    check("R4 pop valid", 80'(rd_valid), 80'd1);
    check("R4 tos up", 80'(tos), 80'd5);
    do_op(3'd2, 3'd0, '0);
    do_op(3'd2, 3'd0, '0);
    do_op(3'd2, 3'd0, '0);
    check("R4 pop last", rd_data, V_NORM);
    check("R4 tos wrap", 80'(tos), 80'd0);
    check("R4 no unf yet", 80'(unf_flag), 80'd0);
    do_op(3'd2, 3'd0, '0);
    check("R4 unf set", 80'(unf_flag), 80'd1);
    check("R4 tos held", 80'(tos), 80'd0);
    do_reset();
    do_op(3'd3, 3'd5, '0);
    check("R5 read empty unf", 80'(unf_flag), 80'd1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 8; k++) do_op(3'd1, 3'd0, V_NORM + 80'(k));
    check("R3 full no ovf", 80'(ovf_flag), 80'd0);
    do_op(3'd1, 3'd0, V_NEG);
    check("R3 ovf set", 80'(ovf_flag), 80'd1);
    check("R3 tos kept", 80'(tos), 80'd0);
    do_op(3'd3, 3'd0, '0);
    check("R3 top unchanged", rd_data, V_NORM + 80'd7);
    do_op(3'd0, 3'd0, '0);
    check("R3 ovf sticky", 80'(ovf_flag), 80'd1);
  endtask

  task automatic t_flat_and_empty();
    do_reset();
    do_op(3'd1, 3'd0, V_NORM);
    do_op(3'd6, 3'd2, 80'hABCD_1122_3344_5566_7788);
    check("R7 tos zero", 80'(tos), 80'd0);
    do_op(3'd5, 3'd2, '0);
    check("R8 flat data", rd_data, 80'h0000_1122_3344_5566_7788);
    check("R8 flat tag", 80'(rd_tag), 80'd0);
    do_op(3'd3, 3'd2, '0);
    check("R7 high ones", rd_data, 80'hFFFF_1122_3344_5566_7788);
    check("R7 tag valid", 80'(rd_tag), 80'd0);
    do_op(3'd3, 3'd6, '0);
    check("R7 all valid no unf", 80'(unf_flag), 80'd0);
    do_op(3'd2, 3'd0, '0);
    check("R4 pop from flat", 80'(tos), 80'd1);
    do_op(3'd5, 3'd2, '0);
    check("R8 no offset", rd_data, 80'h0000_1122_3344_5566_7788);
    do_op(3'd7, 3'd0, '0);
    check("R9 tos kept", 80'(tos), 80'd1);
    do_op(3'd5, 3'd2, '0);
    check("R9 data kept", rd_data, 80'h0000_1122_3344_5566_7788);
    check("R9 tag empty", 80'(rd_tag), 80'd3);
    check("R8 flat no unf", 80'(unf_flag), 80'd0);
    do_op(3'd3, 3'd1, '0);
    check("R9 read empties unf", 80'(unf_flag), 80'd1);
    op_valid = 1'b0; op_code = 3'd1; op_wdata = V_NEG;
    @(negedge clk);
    op_code = 3'd0;
    check("R10 invalid ignored", 80'(tos), 80'd1);
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = 3'd0; op_idx = 3'd0; op_wdata = '0;
    t_reset();
    t_push_classes();
    t_pop_underflow();
    t_overflow();
    t_flat_and_empty();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule